// File: doc/BRIEF.md
# I2C Bus-Speed Divider Solver

This unit converts a source clock rate and a wanted I2C bus rate into the settings for a two-stage clock divider. Both rates arrive in kHz. The first stage is the sample count and the second is the step count. The bus clock period spans twice their product. From the wanted rate the unit picks either normal mode (standard or fast bus) or high-speed mode. It then searches for the pair of counts whose product is the smallest one that is not below the required division. The result comes out as two 16-bit words, ready to be written into the clock generator's timing registers.

A request starts with a one-cycle `start` pulse. The unit captures both rates, checks them, and works out the minimum division with a multi-cycle restoring divider. It then tries sample counts 1 to 8 in turn, and each trial costs one more division. When it finishes, it pulses `done` and holds the words and flags until the next result. Requests that can never be met are flagged as invalid. Requests for which no allowed pair is slow enough are flagged as unsupported.

Top module: `i2c_div_solver`

## Requirements
- R1: A source or requested rate of zero sets `invalid`=1 and `unsupported`=0, and drives both words to zero. `done` rises on the same clock edge that samples `start`, and no search takes place.
- R2: A requested rate above 3400 kHz is handled in the same way as R1 (invalid, words zero, immediate `done`).
- R3: A requested rate above 400 kHz selects high-speed mode (`hs_mode`=1, step limit 8). A rate of 400 kHz or less selects normal mode (`hs_mode`=0, step limit 64).
- R4: The minimum division is ceil(floor(src/2) / req). A result of zero is raised to 1.
- R5: The search starts from the default pair (sample 8, step = limit) with best product 8×limit. For sample s = 1 to 8 in order it computes step = ceil(min_div/s) and skips the candidate when step > limit. A strictly smaller product replaces the best pair. The search stops right after a replacement whose product equals the minimum division.
- R6: `unsupported`=1 when floor(src / (2·sample·step)) > req for the chosen pair. The words are still encoded from that pair.
- R7: In normal mode, timing word bits [5:0] = step−1 and bits [10:8] = sample−1, with all other bits 0. The high-speed word is 0x0000.
- R8: In high-speed mode the timing word is 0x1303. The high-speed word is 0x0003 with bits [10:8] = step−1 and bits [14:12] = sample−1.
- R9: `done` is a one-cycle pulse, given once for each accepted `start`. A `start` that arrives while a search is running is ignored, and so are changes to the rate inputs after capture. A valid request completes within 9·(W+2)+1 clock edges of the edge that samples `start` (W = rate width, 32).
- R10: After reset, `done`, both flags, `hs_mode` and both words are 0. Outputs keep their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse, accepted only when idle |
| src_khz | input | 32 | Source clock rate in kHz |
| req_khz | input | 32 | Requested bus rate in kHz |
| done | output | 1 | One-cycle result strobe |
| invalid | output | 1 | Request rejected (zero rate or above 3400 kHz) |
| unsupported | output | 1 | Resulting bus rate exceeds the request |
| hs_mode | output | 1 | High-speed mode chosen |
| timing_word | output | 16 | Encoded timing word |
| hs_word | output | 16 | Encoded high-speed word |

## Verification
An invalid request has its result due on the very edge that samples `start`. A valid request waits for one division to find the minimum and then one division per sample count tried, each taking W+2 edges. Its result is therefore due between 2·(W+2)+1 and 9·(W+2)+1 edges after the start edge, and the bench checks that the measured latency falls in that window. The monitor samples on the falling clock edge. It pops the expected item only when `done` is seen, and it treats any `done` that arrives with an empty queue as a failure. This is how a start issued in mid-search is shown to be ignored.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

    localparam int unsigned SMP_MAX        = 8;
    localparam int unsigned STEP_LIM_NORM  = 64;
    localparam int unsigned STEP_LIM_HS    = 8;
    localparam int unsigned HS_THRESH_KHZ  = 400;
    localparam int unsigned MAX_RATE_KHZ   = 3400;
    localparam int unsigned SMP_W          = $clog2(SMP_MAX) + 1;
    localparam int unsigned STP_W          = $clog2(STEP_LIM_NORM) + 1;

    localparam logic [15:0] HS_TIMING_WORD = 16'h1303;
    localparam logic [15:0] HS_WORD_BASE   = 16'h0003;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIN_GO,
        ST_MIN_WAIT,
        ST_STEP_GO,
        ST_STEP_WAIT,
        ST_RATE
    } state_t;

    // Divider pair held as true counts (not minus one)
    typedef struct packed {
        logic [SMP_W-1:0] smp;
        logic [STP_W-1:0] stp;
    } divpair_t;

    typedef struct packed {
        logic [15:0] timing;
        logic [15:0] hs;
    } words_t;

    function automatic logic [STP_W-1:0] step_limit(input logic hs);
        return hs ? STP_W'(STEP_LIM_HS) : STP_W'(STEP_LIM_NORM);
    endfunction

endpackage

// File: rtl/i2cds_ceil_div.sv
module i2cds_ceil_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         rdy,
    output logic [W-1:0] quo_ceil
);
    localparam int unsigned CNT_W = $clog2(W) + 1;

    logic [W-1:0]     q;
    logic [W-1:0]     d;
    logic [W:0]       r;
    logic [CNT_W-1:0] cnt;

    logic [W:0]   r_sh;
    logic         ge;
    logic [W:0]   r_nx;
    logic [W-1:0] q_nx;

    // One restoring step: shift in next dividend bit, subtract when it fits
    always_comb begin
        r_sh = {r[W-1:0], q[W-1]};
        ge   = (r_sh >= {1'b0, d});
        r_nx = ge ? (r_sh - {1'b0, d}) : r_sh;
        q_nx = {q[W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            d        <= '0;
            r        <= '0;
            cnt      <= '0;
            busy     <= 1'b0;
            rdy      <= 1'b0;
            quo_ceil <= '0;
        end else begin
            rdy <= 1'b0;
            if (go && !busy) begin
                q    <= num;
                d    <= den;
                r    <= '0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                q   <= q_nx;
                r   <= r_nx;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(W - 1)) begin
                    busy     <= 1'b0;
                    rdy      <= 1'b1;
                    quo_ceil <= q_nx + W'(r_nx != '0);
                end
            end
        end
    end

    AST_DIV_GO_IDLE: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);  // R9
    AST_DIV_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy);  // R9

endmodule

// File: rtl/i2cds_encode.sv
module i2cds_encode
    import i2cds_pkg::*;
(
    input  logic     hs,
    input  divpair_t pair,
    output words_t   words
);
    logic [SMP_W-1:0] sm1;
    logic [STP_W-1:0] st1;

    always_comb begin
        sm1 = pair.smp - 1'b1;
        st1 = pair.stp - 1'b1;
        if (hs) begin
            words.timing = HS_TIMING_WORD;
            words.hs     = HS_WORD_BASE | {1'b0, sm1[2:0], 1'b0, st1[2:0], 8'h00};
        end else begin
            words.timing = {5'b0, sm1[2:0], 2'b0, st1[5:0]};
            words.hs     = 16'h0000;
        end
    end

endmodule

// File: rtl/i2c_div_solver.sv
module i2c_div_solver
    import i2cds_pkg::*;
#(
    parameter int unsigned RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] src_khz,
    input  logic [RATE_W-1:0] req_khz,
    output logic              done,
    output logic              invalid,
    output logic              unsupported,
    output logic              hs_mode,
    output logic [15:0]       timing_word,
    output logic [15:0]       hs_word
);
    localparam int unsigned PROD_W = RATE_W + SMP_W;
    localparam int unsigned TH_W   = 2 * RATE_W;
    localparam int unsigned DEN_W  = SMP_W + STP_W + 1;

    state_t            st;
    logic [RATE_W-1:0] src_q;
    logic [RATE_W-1:0] req_q;
    logic              hs_q;
    logic [STP_W-1:0]  lim;
    logic [RATE_W-1:0] min_div;
    logic [SMP_W-1:0]  smp;
    divpair_t          best;
    logic [PROD_W-1:0] best_prod;

    logic              div_go;
    logic [RATE_W-1:0] div_num;
    logic [RATE_W-1:0] div_den;
    logic              div_busy;
    logic              div_rdy;
    logic [RATE_W-1:0] div_res;

    logic              req_bad;
    logic              req_hs;
    logic [STP_W-1:0]  req_lim;
    logic [PROD_W-1:0] cand_prod;
    logic              cand_fits;
    logic              cand_better;
    logic [DEN_W-1:0]  rate_den;
    logic [TH_W-1:0]   rate_thresh;
    logic              too_fast;
    words_t            enc;

    // ---------------- request screening ----------------
    always_comb begin
        req_bad = (src_khz == '0) || (req_khz == '0) ||
                  (req_khz > RATE_W'(MAX_RATE_KHZ));
        req_hs  = (req_khz > RATE_W'(HS_THRESH_KHZ));
        req_lim = step_limit(req_hs);
    end

    // ---------------- shared divider ----------------
    always_comb begin
        div_go  = (st == ST_MIN_GO) || (st == ST_STEP_GO);
        div_num = (st == ST_MIN_GO) ? (src_q >> 1) : min_div;
        div_den = (st == ST_MIN_GO) ? req_q : RATE_W'(smp);
    end

    i2cds_ceil_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .num      (div_num),
        .den      (div_den),
        .busy     (div_busy),
        .rdy      (div_rdy),
        .quo_ceil (div_res)
    );

    // ---------------- candidate evaluation ----------------
    always_comb begin
        cand_fits   = (div_res <= RATE_W'(lim));
        cand_prod   = PROD_W'(div_res) * PROD_W'(smp);
        cand_better = cand_fits && (cand_prod < best_prod);
    end

    // ---------------- achieved-rate check ----------------
    // floor(src/den) > req  <=>  src >= (req+1)*den
    always_comb begin
        rate_den    = DEN_W'(2) * DEN_W'(best.smp) * DEN_W'(best.stp);
        rate_thresh = (TH_W'(req_q) + TH_W'(1)) * TH_W'(rate_den);
        too_fast    = (TH_W'(src_q) >= rate_thresh);
    end

    i2cds_encode u_enc (
        .hs    (hs_q),
        .pair  (best),
        .words (enc)
    );

    // ---------------- control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            src_q       <= '0;
            req_q       <= '0;
            hs_q        <= 1'b0;
            lim         <= STP_W'(STEP_LIM_NORM);
            min_div     <= RATE_W'(1);
            smp         <= SMP_W'(1);
            best.smp    <= SMP_W'(SMP_MAX);
            best.stp    <= STP_W'(STEP_LIM_NORM);
            best_prod   <= PROD_W'(SMP_MAX * STEP_LIM_NORM);
            done        <= 1'b0;
            invalid     <= 1'b0;
            unsupported <= 1'b0;
            hs_mode     <= 1'b0;
            timing_word <= '0;
            hs_word     <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        src_q <= src_khz;
                        req_q <= req_khz;
                        if (req_bad) begin
                            done        <= 1'b1;
                            invalid     <= 1'b1;
                            unsupported <= 1'b0;
                            hs_mode     <= 1'b0;
                            timing_word <= '0;
                            hs_word     <= '0;
                        end else begin
                            hs_q      <= req_hs;
                            lim       <= req_lim;
                            best.smp  <= SMP_W'(SMP_MAX);
                            best.stp  <= req_lim;
                            best_prod <= PROD_W'(SMP_MAX) * PROD_W'(req_lim);
                            st        <= ST_MIN_GO;
                        end
                    end
                end
                ST_MIN_GO: st <= ST_MIN_WAIT;
                ST_MIN_WAIT: begin
                    if (div_rdy) begin
                        min_div <= (div_res == '0) ? RATE_W'(1) : div_res;
                        smp     <= SMP_W'(1);
                        st      <= ST_STEP_GO;
                    end
                end
                ST_STEP_GO: st <= ST_STEP_WAIT;
                ST_STEP_WAIT: begin
                    if (div_rdy) begin
                        if (cand_better) begin
                            best.smp  <= smp;
                            best.stp  <= div_res[STP_W-1:0];
                            best_prod <= cand_prod;
                        end
                        if (cand_better && (cand_prod == PROD_W'(min_div))) begin
                            st <= ST_RATE;
                        end else if (smp == SMP_W'(SMP_MAX)) begin
                            st <= ST_RATE;
                        end else begin
                            smp <= smp + 1'b1;
                            st  <= ST_STEP_GO;
                        end
                    end
                end
                ST_RATE: begin
                    done        <= 1'b1;
                    invalid     <= 1'b0;
                    unsupported <= too_fast;
                    hs_mode     <= hs_q;
                    timing_word <= enc.timing;
                    hs_word     <= enc.hs;
                    st          <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9
    AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done && invalid) |-> (timing_word == '0 && hs_word == '0 && !unsupported));  // R1
    AST_HS_TIMING_FIXED: assert property (@(posedge clk) disable iff (rst)
        (done && !invalid && hs_mode) |-> (timing_word == HS_TIMING_WORD));  // R8
    AST_NORM_HS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && !invalid && !hs_mode) |-> (hs_word == 16'h0000));  // R7
    AST_STEP_IN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |-> (best.stp <= lim && best.stp != '0));  // R5
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(timing_word) && $stable(hs_word) && $stable(invalid)) || done);  // R10

endmodule

// File: tb/tb_i2c_div_solver.sv
module tb_i2c_div_solver;

    localparam int W       = 32;
    localparam int LAT_MAX = 9 * (W + 2) + 1;
    localparam int LAT_MIN = 2 * (W + 2) + 1;

    typedef struct {
        string       tag;
        int          t0;
        bit          inv;
        bit          uns;
        bit          hs;
        logic [15:0] tw;
        logic [15:0] hw;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] src_khz = '0;
    logic [31:0] req_khz = '0;
    logic        done, invalid, unsupported, hs_mode;
    logic [15:0] timing_word, hs_word;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   extra_done = 0;
    exp_t expq[$];

    always #2.5 clk = ~clk;  // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    i2c_div_solver dut (
        .clk(clk), .rst(rst), .start(start),
        .src_khz(src_khz), .req_khz(req_khz),
        .done(done), .invalid(invalid), .unsupported(unsupported),
        .hs_mode(hs_mode), .timing_word(timing_word), .hs_word(hs_word)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Independent model built from the requirements
    function automatic exp_t model(input longint src, input longint req, input string tag);
        exp_t e;
        longint lim, half, md, bs, bt, bp, stp;
        e.tag = tag; e.t0 = 0;
        e.inv = 0; e.uns = 0; e.hs = 0; e.tw = 0; e.hw = 0;
        if (src == 0 || req == 0 || req > 3400) begin
            e.inv = 1;
            return e;
        end
        e.hs = (req > 400);
        lim  = e.hs ? 8 : 64;
        half = src / 2;
        md   = (half + req - 1) / req;
        if (md == 0) md = 1;
        bs = 8; bt = lim; bp = 8 * lim;
        for (int s = 1; s <= 8; s++) begin
            stp = (md + s - 1) / s;
            if (stp > lim) continue;
            if (stp * s < bp) begin
                bp = stp * s; bs = s; bt = stp;
                if (bp == md) break;
            end
        end
        e.uns = (src / (2 * bs * bt)) > req;
        if (e.hs) begin
            e.tw = 16'h1303;
            e.hw = 16'h0003 | 16'((bt - 1) << 8) | 16'((bs - 1) << 12);
        end else begin
            e.tw = 16'((bt - 1) | ((bs - 1) << 8));
            e.hw = 16'h0000;
        end
        return e;
    endfunction

    task automatic issue(input longint src, input longint req, input string tag);
        exp_t e;
        e = model(src, req, tag);
        @(negedge clk);
        start   = 1'b1;
        src_khz = 32'(src);
        req_khz = 32'(req);
        e.t0    = cyc + 1;
        expq.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_empty;
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input longint src, input longint req, input string tag);
        issue(src, req, tag);
        wait_empty();
    endtask

    // Monitor / scoreboard
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done) begin
                checks++; errors++;
                $display("FAIL R9 done high two cycles actual=1 expected=0");
            end
            if (done) begin
                if (expq.size() == 0) begin
                    extra_done++;
                end else begin
                    exp_t e;
                    int lat;
                    e = expq.pop_front();
                    lat = cyc - e.t0;
                    if (e.inv) chk("R1", "latency", lat, 0);
                    else begin
                        checks++;
                        if (lat < LAT_MIN || lat > LAT_MAX) begin
                            errors++;
                            $display("FAIL R9 latency actual=%0d expected=%0d..%0d", lat, LAT_MIN, LAT_MAX);
                        end
                    end
                    chk(e.tag, "invalid", invalid, e.inv);
                    chk(e.tag, "unsupported", unsupported, e.uns);
                    chk(e.tag, "hs_mode", hs_mode, e.hs);
                    chk(e.tag, "timing_word", timing_word, e.tw);
                    chk(e.tag, "hs_word", hs_word, e.hw);
                end
            end
            prev_done = done;
        end
    end

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held_tw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "reset done", done, 0);
        chk("R10", "reset invalid", invalid, 0);
        chk("R10", "reset unsupported", unsupported, 0);
        chk("R10", "reset timing_word", timing_word, 0);
        chk("R10", "reset hs_word", hs_word, 0);

        run(0, 100, "R1");
        run(26000, 0, "R1");
        run(26000, 3401, "R2");
        run(26000, 3400, "R8");
        run(26000, 401, "R3");
        run(26000, 400, "R7");
        run(26000, 100, "R5");
        run(13000, 1000, "R5");
        run(200000, 100, "R6");
        run(1, 1, "R4");
        run(27000, 330, "R4");

        // R10: outputs hold after a result
        held_tw = timing_word;
        repeat (20) @(negedge clk);
        chk("R10", "held timing_word", timing_word, held_tw);

        // R9: start and input changes during a search are ignored
        issue(26000, 100, "R9");
        repeat (20) @(negedge clk);
        start = 1'b1; src_khz = 0; req_khz = 0;
        @(negedge clk);
        start = 1'b0; src_khz = 32'd5; req_khz = 32'd3000;
        wait_empty();
        repeat (LAT_MAX + 5) @(negedge clk);
        chk("R9", "extra done pulses", extra_done, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule